// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter with Clear-to-Send Gating

This block sends characters over an asynchronous serial line. It has two storage stages. Software writes a character into a holding buffer. When a frame may begin, the block moves the character into a shift register and sends it on `txd`, least significant bit first. Because of the two stages, software can write the next character while the current one is still being sent. The data length (7, 8 or 9 bits), an optional even or odd parity bit, one or two stop bits and optional clear-to-send gating are all set by configuration inputs. The configuration is sampled at the moment a character moves into the shift register.

The bit timing comes from a free-running prescaler and a reload down-counter. The prescaler divides the clock by 2, 16 or 64, or an external tick input is used instead. The reload counter divides that source by n+1. A further divide by 16 then gives one bit time. A new frame can only start at a check point. A check point is a bit boundary that occurs either while the line is idle or at the end of the last stop bit. At a check point the enable input, the buffer state and clear-to-send decide whether the next frame starts. When they allow it, the next start bit follows the final stop bit directly.

Status is reported on three outputs. `buf_empty` shows the holding buffer is free. `reg_empty` shows the line is idle. `irq` is a sticky request that is raised on every transfer into the shift register and cleared by an acknowledge pulse.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset, `txd`=1, `buf_empty`=1, `reg_empty`=1 and `irq`=0. `txd` stays 1 whenever no frame is active.
- R2: A frame is sent in this order: a low start bit, then the data bits starting from bit 0, then the optional parity bit, then the stop bits. The data length is set by `len_sel`: 0 gives 7 bits, 1 or 3 gives 8 bits, and 2 gives 9 bits, taken from `wr_data`.
- R3: When `par_en`=1, a parity bit follows the data. It equals the XOR of the data bits when `par_odd`=0, and the inverse of that XOR when `par_odd`=1. When `par_en`=0, no parity bit is sent.
- R4: A frame ends with one high stop bit, or with two when `two_stop`=1.
- R5: One bit lasts 16·(n+1) ticks of the selected source, where n is `reload`. The source is chosen by `src_sel`: 0 is clock/2, 1 is clock/16, 2 is clock/64, and 3 is the `ext_tick` pulses. Bit boundaries fall on source tick 15(n+1)+16(n+1)k, counted from reset.
- R6: A write pulse clears `buf_empty` in the next cycle and stores the character, replacing any held one. A transfer into the shift register sets `buf_empty` in the next cycle, unless a write occurs in the same cycle.
- R7: A frame starts only at a check point. When the start conditions hold at the end of the last stop bit, the next start bit follows with no idle bit.
- R8: When `cts_en`=1 and `cts_n`=1 at a check point, no frame starts and the character stays in the buffer. When `cts_en`=0, `cts_n` has no effect.
- R9: When `tx_en`=0 at a check point, no frame starts. The buffered character is kept until `tx_en` returns to 1.
- R10: `reg_empty` is 0 while a frame is being sent. It becomes 1 after the last stop bit only if no new frame starts.
- R11: `irq` is set in the cycle after each transfer into the shift register. It stays set until `irq_ack` is pulsed. When a transfer and an acknowledge occur in the same cycle, the set wins.
- R12: The format and data of a frame are fixed at transfer time. Changes to the configuration inputs during a frame do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_sel | input | 2 | Bit-clock source: 0 clk/2, 1 clk/16, 2 clk/64, 3 external ticks |
| ext_tick | input | 1 | External source tick, one-cycle pulses |
| reload | input | RELOAD_W | Reload value n of the bit-rate counter |
| len_sel | input | 2 | Data length: 0 seven, 1 or 3 eight, 2 nine |
| par_en | input | 1 | Parity bit enable |
| par_odd | input | 1 | Odd parity when 1, even when 0 |
| two_stop | input | 1 | Two stop bits when 1 |
| cts_en | input | 1 | Enables clear-to-send gating |
| cts_n | input | 1 | Clear-to-send, active low |
| tx_en | input | 1 | Transmit enable |
| wr_stb | input | 1 | One-cycle write pulse into the holding buffer |
| wr_data | input | DATA_W | Character to write |
| irq_ack | input | 1 | Clears the interrupt request |
| txd | output | 1 | Serial output, idles high |
| buf_empty | output | 1 | Holding buffer is free |
| reg_empty | output | 1 | No frame is active |
| irq | output | 1 | Sticky transmit interrupt request |

## Verification
The bench uses the default parameters. DATA_W=9 makes 9-bit frames possible, and PRE_W=6 covers all three internal dividers. The bench changes `reload` between resets: n=0 and n=2. These values give bit times from 32 to 1024 clocks, so every source selection, including external ticks, can be exercised within the run. Within these runs the bench covers frames sent back to back, writes that replace a held character, blocking by clear-to-send and by enable, and configuration changes made during a frame. All of these are compared clock by clock against a behavioural model of the bit queue.

// File: rtl/uart_txb_pkg.sv
package uart_txb_pkg;

  typedef enum logic [1:0] {
    SRC_DIV2  = 2'd0,
    SRC_DIV16 = 2'd1,
    SRC_DIV64 = 2'd2,
    SRC_EXT   = 2'd3
  } src_e;

  typedef struct packed {
    logic [1:0] len_sel;
    logic       par_en;
    logic       par_odd;
    logic       two_stop;
  } fmt_t;

  localparam int SH_DIV2  = 1;
  localparam int SH_DIV16 = 4;
  localparam int SH_DIV64 = 6;

endpackage

// File: rtl/uart_txb_baud.sv
module uart_txb_baud
  import uart_txb_pkg::*;
#(
  parameter int PRE_W    = 6,
  parameter int RELOAD_W = 8,
  parameter int OVS      = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          src_sel,
  input  logic                ext_tick,
  input  logic [RELOAD_W-1:0] reload,
  output logic                bit_tick
);

  localparam int OVS_W = $clog2(OVS);

  logic [PRE_W-1:0]    pre_q, pre_d;
  logic [RELOAD_W-1:0] rc_q, rc_d;
  logic [OVS_W-1:0]    ph_q, ph_d;
  logic                src_tick, sub_tick;
  src_e                sel;

  assign sel = src_e'(src_sel);

  always_comb begin
    unique case (sel)
      SRC_DIV2:  src_tick = &pre_q[SH_DIV2-1:0];
      SRC_DIV16: src_tick = &pre_q[SH_DIV16-1:0];
      SRC_DIV64: src_tick = &pre_q[SH_DIV64-1:0];
      default:   src_tick = ext_tick;
    endcase
  end

  assign sub_tick = src_tick && (rc_q == '0);
  assign bit_tick = sub_tick && (ph_q == OVS_W'(OVS - 1));

  always_comb begin
    pre_d = pre_q + 1'b1;
    rc_d  = rc_q;
    ph_d  = ph_q;
    if (src_tick) begin
      if (rc_q == '0) rc_d = reload;
      else            rc_d = rc_q - 1'b1;
    end
    if (sub_tick) ph_d = ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      rc_q  <= '0;
      ph_q  <= '0;
    end else begin
      pre_q <= pre_d;
      rc_q  <= rc_d;
      ph_q  <= ph_d;
    end
  end

  // R5
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);

endmodule

// File: rtl/uart_txb_ctrl.sv
module uart_txb_ctrl #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chk,
  input  logic              tx_en,
  input  logic              cts_en,
  input  logic              cts_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              irq_ack,
  output logic              go,
  output logic [DATA_W-1:0] hold_data,
  output logic              buf_empty,
  output logic              irq
);

  logic [DATA_W-1:0] hold_q, hold_d;
  logic              empty_q, empty_d;
  logic              irq_q, irq_d;
  logic              cts_ok;

  assign cts_ok = !cts_en || !cts_n;
  assign go     = chk && tx_en && !empty_q && cts_ok;

  always_comb begin
    hold_d  = hold_q;
    empty_d = empty_q;
    irq_d   = irq_q;
    if (wr_stb) begin
      hold_d  = wr_data;
      empty_d = 1'b0;
    end else if (go) begin
      empty_d = 1'b1;
    end
    if (go)           irq_d = 1'b1;
    else if (irq_ack) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      empty_q <= 1'b1;
      irq_q   <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      empty_q <= empty_d;
      irq_q   <= irq_d;
    end
  end

  assign hold_data = hold_q;
  assign buf_empty = empty_q;
  assign irq       = irq_q;

  // R6
  wr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !buf_empty);

  // R6
  load_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !wr_stb) |=> buf_empty);

  // R11
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> irq);

  // R11
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_ack) |=> irq);

  // R8
  cts_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk && cts_en && cts_n && !wr_stb) |=> $stable(buf_empty));

  // R9
  en_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk && !tx_en && !wr_stb) |=> $stable(buf_empty));

endmodule

// File: rtl/uart_txb_shift.sv
module uart_txb_shift
  import uart_txb_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              go,
  input  logic [DATA_W-1:0] data,
  input  fmt_t              fmt,
  output logic              chk,
  output logic              txd,
  output logic              busy
);

  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sr_q, sr_d, frame;
  logic [CNT_W-1:0]   left_q, left_d, count, dlen;
  logic               busy_q, busy_d;
  logic [DATA_W-1:0]  dmask, dsel;
  logic [FRAME_W-1:0] body;
  logic               par_bit;

  always_comb begin
    unique case (fmt.len_sel)
      2'd0:    dlen = CNT_W'(7);
      2'd2:    dlen = CNT_W'(DATA_W);
      default: dlen = CNT_W'(8);
    endcase
    dmask   = ~({DATA_W{1'b1}} << dlen);
    dsel    = data & dmask;
    par_bit = (^dsel) ^ fmt.par_odd;
    body    = ({FRAME_W{1'b1}} << dlen) | FRAME_W'(dsel);
    if (fmt.par_en)
      body = (body & ~(FRAME_W'(1) << dlen)) | (FRAME_W'(par_bit) << dlen);
    frame = {body[FRAME_W-2:0], 1'b0};
    count = CNT_W'(2) + dlen + CNT_W'(fmt.par_en) + CNT_W'(fmt.two_stop);
  end

  assign chk = bit_tick && (!busy_q || (left_q == CNT_W'(1)));

  always_comb begin
    sr_d   = sr_q;
    left_d = left_q;
    busy_d = busy_q;
    if (chk) begin
      if (go) begin
        sr_d   = frame;
        left_d = count;
        busy_d = 1'b1;
      end else begin
        sr_d   = '1;
        left_d = '0;
        busy_d = 1'b0;
      end
    end else if (bit_tick && busy_q) begin
      sr_d   = {1'b1, sr_q[FRAME_W-1:1]};
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q   <= '1;
      left_q <= '0;
      busy_q <= 1'b0;
    end else begin
      sr_q   <= sr_d;
      left_q <= left_d;
      busy_q <= busy_d;
    end
  end

  assign txd  = sr_q[0];
  assign busy = busy_q;

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> txd);

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !txd);

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !chk) |=> busy_q);

endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf
  import uart_txb_pkg::*;
#(
  parameter int DATA_W   = 9,
  parameter int PRE_W    = 6,
  parameter int RELOAD_W = 8,
  parameter int OVS      = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          src_sel,
  input  logic                ext_tick,
  input  logic [RELOAD_W-1:0] reload,
  input  logic [1:0]          len_sel,
  input  logic                par_en,
  input  logic                par_odd,
  input  logic                two_stop,
  input  logic                cts_en,
  input  logic                cts_n,
  input  logic                tx_en,
  input  logic                wr_stb,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                irq_ack,
  output logic                txd,
  output logic                buf_empty,
  output logic                reg_empty,
  output logic                irq
);

  logic              rs1_q, rst_sync;
  logic              bit_tick, chk, go, busy;
  logic [DATA_W-1:0] hold_data;
  fmt_t              fmt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q    <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rs1_q    <= 1'b1;
      rst_sync <= rs1_q;
    end
  end

  assign fmt = '{len_sel: len_sel, par_en: par_en, par_odd: par_odd,
                 two_stop: two_stop};

  uart_txb_baud #(
    .PRE_W(PRE_W), .RELOAD_W(RELOAD_W), .OVS(OVS)
  ) u_baud (
    .clk(clk), .rst_n(rst_sync), .src_sel(src_sel), .ext_tick(ext_tick),
    .reload(reload), .bit_tick(bit_tick)
  );

  uart_txb_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_sync), .chk(chk), .tx_en(tx_en),
    .cts_en(cts_en), .cts_n(cts_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .irq_ack(irq_ack), .go(go), .hold_data(hold_data),
    .buf_empty(buf_empty), .irq(irq)
  );

  uart_txb_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_sync), .bit_tick(bit_tick), .go(go),
    .data(hold_data), .fmt(fmt), .chk(chk), .txd(txd), .busy(busy)
  );

  assign reg_empty = !busy;

  // R10
  empty_rise_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    $rose(reg_empty) |-> txd);

endmodule

// File: tb/uart_tx_dbuf_test.sv
module uart_tx_dbuf_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] src_sel;
  logic       ext_tick;
  logic [7:0] reload;
  logic [1:0] len_sel;
  logic       par_en, par_odd, two_stop, cts_en, cts_n, tx_en;
  logic       wr_stb;
  logic [8:0] wr_data;
  logic       irq_ack;
  logic       txd, buf_empty, reg_empty, irq;

  always #10 clk = ~clk;

  uart_tx_dbuf uut (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .ext_tick(ext_tick),
    .reload(reload), .len_sel(len_sel), .par_en(par_en), .par_odd(par_odd),
    .two_stop(two_stop), .cts_en(cts_en), .cts_n(cts_n), .tx_en(tx_en),
    .wr_stb(wr_stb), .wr_data(wr_data), .irq_ack(irq_ack), .txd(txd),
    .buf_empty(buf_empty), .reg_empty(reg_empty), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit ext_on = 1'b0;
  int ext_cnt = 0;

  // behavioural reference model
  bit       m_r1, m_r2, m_act, m_bempty, m_irq;
  bit       m_q[$];
  bit [8:0] m_buf;
  int       m_cyc, m_sidx;

  task automatic model_reset();
    m_act = 0; m_q.delete(); m_buf = '0; m_bempty = 1; m_irq = 0;
    m_cyc = 0; m_sidx = 0;
  endtask

  task automatic model_build();
    int  len;
    bit  p;
    len = (len_sel == 2'd0) ? 7 : (len_sel == 2'd2) ? 9 : 8;
    p = par_odd;
    m_q.delete();
    m_q.push_back(1'b0);
    for (int i = 0; i < len; i++) begin
      m_q.push_back(m_buf[i]);
      p ^= m_buf[i];
    end
    if (par_en) m_q.push_back(p);
    m_q.push_back(1'b1);
    if (two_stop) m_q.push_back(1'b1);
  endtask

  task automatic model_step();
    int ratio, per;
    bit src, btick, chkp, load;
    ratio = (src_sel == 2'd0) ? 2 : (src_sel == 2'd1) ? 16 : 64;
    src = (src_sel == 2'd3) ? ext_tick : ((m_cyc % ratio) == ratio - 1);
    m_cyc++;
    btick = 0;
    if (src) begin
      per = 16 * (int'(reload) + 1);
      btick = (m_sidx % per) == 15 * (int'(reload) + 1);
      m_sidx++;
    end
    chkp = btick && (!m_act || m_q.size() == 1);
    load = 0;
    if (chkp) begin
      if (tx_en && !m_bempty && (!cts_en || !cts_n)) begin
        model_build();
        m_act = 1;
        load = 1;
      end else begin
        m_act = 0;
        m_q.delete();
      end
    end else if (btick && m_act) begin
      void'(m_q.pop_front());
    end
    if (load) begin m_bempty = 1; m_irq = 1; end
    if (wr_stb) begin m_buf = wr_data; m_bempty = 0; end
    if (irq_ack && !load) m_irq = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_r1 = 0; m_r2 = 0; model_reset();
    end else begin
      if (!m_r2) model_reset(); else model_step();
      m_r2 = m_r1; m_r1 = 1;
    end
  end

  task automatic check_bit(input string tag, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      check_bit("R2 R3 R4 R5 R7 R12 txd", txd, m_act ? m_q[0] : 1'b1);
      check_bit("R6 buf_empty", buf_empty, m_bempty);
      check_bit("R10 reg_empty", reg_empty, !m_act);
      check_bit("R11 irq", irq, m_irq);
    end
  end

  // external source ticks every third cycle
  always @(negedge clk) begin
    if (ext_on) begin
      ext_cnt = (ext_cnt + 1) % 3;
      ext_tick <= (ext_cnt == 0);
    end else begin
      ext_tick <= 1'b0;
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cycles);
      finish_run();
    end
  end

  task automatic do_reset(input logic [7:0] n, input logic [1:0] sel);
    @(negedge clk);
    rst_n = 1'b0; reload = n; src_sel = sel;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_write(input logic [8:0] d);
    @(negedge clk);
    wr_stb = 1'b1; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic wait_idle();
    int lim = 0;
    while (!(buf_empty && reg_empty) && lim < 40000) begin
      @(negedge clk); lim++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic wait_buf_free();
    int lim = 0;
    while (!buf_empty && lim < 40000) begin
      @(negedge clk); lim++;
    end
  endtask

  task automatic set_fmt(input logic [1:0] l, input bit pe, input bit po, input bit ts);
    len_sel = l; par_en = pe; par_odd = po; two_stop = ts;
  endtask

  initial begin
    rst_n = 1'b0; src_sel = 2'd0; ext_tick = 1'b0; reload = 8'd0;
    len_sel = 2'd1; par_en = 0; par_odd = 0; two_stop = 0;
    cts_en = 0; cts_n = 1; tx_en = 1; wr_stb = 0; wr_data = '0; irq_ack = 0;

    do_reset(8'd0, 2'd0);
    // R1 reset state
    check_bit("R1 reset txd", txd, 1'b1);
    check_bit("R1 reset buf_empty", buf_empty, 1'b1);
    check_bit("R1 reset reg_empty", reg_empty, 1'b1);
    check_bit("R1 reset irq", irq, 1'b0);

    // R2 eight data bits, no parity, one stop
    set_fmt(2'd1, 0, 0, 0);
    do_write(9'h0A5);
    wait_idle();
    // R7 back-to-back frames
    do_write(9'h03C);
    wait_buf_free();
    do_write(9'h0C3);
    wait_buf_free();
    do_write(9'h1FF);
    wait_idle();

    // R3 R4 seven bits even parity two stops, nine bits odd parity
    set_fmt(2'd0, 1, 0, 1);
    do_write(9'h055);
    wait_idle();
    set_fmt(2'd2, 1, 1, 0);
    do_write(9'h1A6);
    wait_idle();
    set_fmt(2'd3, 1, 1, 1);
    do_write(9'h000);
    wait_idle();

    // R11 acknowledge clears the request
    check_bit("R11 irq before ack", irq, 1'b1);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    check_bit("R11 irq after ack", irq, 1'b0);

    // R8 clear-to-send blocks while high
    set_fmt(2'd1, 1, 0, 0);
    cts_en = 1; cts_n = 1;
    do_write(9'h081);
    repeat (600) @(negedge clk);
    check_bit("R8 blocked reg_empty", reg_empty, 1'b1);
    check_bit("R8 blocked buf_empty", buf_empty, 1'b0);
    cts_n = 0;
    wait_idle();
    // R8 ignored when gating is off
    cts_en = 0; cts_n = 1;
    do_write(9'h07E);
    repeat (100) @(negedge clk);
    check_bit("R8 ignored reg_empty", reg_empty, 1'b0);
    wait_idle();

    // R9 enable low holds the buffer; R6 second write replaces it
    tx_en = 0;
    do_write(9'h011);
    do_write(9'h0EE);
    repeat (600) @(negedge clk);
    check_bit("R9 held reg_empty", reg_empty, 1'b1);
    check_bit("R9 held buf_empty", buf_empty, 1'b0);
    tx_en = 1;
    wait_idle();

    // R12 configuration changed mid-frame
    set_fmt(2'd2, 1, 0, 1);
    do_write(9'h133);
    repeat (150) @(negedge clk);
    set_fmt(2'd0, 0, 1, 0);
    wait_idle();

    // R5 slower divider with reload 2
    do_reset(8'd2, 2'd1);
    set_fmt(2'd0, 0, 0, 0);
    do_write(9'h04B);
    wait_idle();

    // R5 external ticks
    ext_on = 1'b1;
    do_reset(8'd0, 2'd3);
    set_fmt(2'd1, 1, 1, 1);
    do_write(9'h0D2);
    wait_buf_free();
    do_write(9'h02D);
    wait_idle();
    ext_on = 1'b0;

    // R5 clock/64 source
    do_reset(8'd0, 2'd2);
    set_fmt(2'd0, 0, 0, 0);
    do_write(9'h06A);
    wait_idle();

    finish_run();
  end

endmodule